// File: doc/BRIEF.md
# Multi-Pattern Receive Sync Detector and Byte Checker

This block sits behind a bit slicer in a half-duplex data receiver. Each received bit comes in with a one-cycle strobe. While hunting, the block compares the most recent sixteen bits against two patterns at once. The first is a fixed network sync word, picked from two standard values by a select input. The second is a sixteen-bit word programmed by the user.

A hit raises a one-cycle flag for the pattern that matched and switches the block into byte-framed mode. In that mode it packs the following bits into bytes and keeps a running CRC-16. After each byte it emits a one-cycle pulse together with the byte and a single bit that says whether the CRC residue is zero at that point. Because that bit comes with every byte, a message and its check field can be any number of bytes long.

The host can start framing itself at any moment with a start pulse. It returns the block to hunting with a re-arm pulse. The receiver works only while its enable is high and the transmitter enable is low.

Top module: `sync_word_detector`

## Requirements
- R1: After synchronous reset, the block is hunting, and `fixed_hit`, `user_hit`, `framing`, `byte_valid`, `byte_data` and `crc_ok` are all zero.
- R2: Bits are compared earliest-received first, so the earliest bit lines up with bit 15 of a pattern. The fixed pattern is 16'hC4D7 (1100010011010111) when `std_sel` is 0 and 16'hB433 (1011010000110011) when `std_sel` is 1. The other value never matches. `fixed_hit` is high for exactly the one cycle after the clock edge that samples the completing strobe.
- R3: `user_word` is compared in parallel with the fixed pattern and sets `user_hit` with the same timing. When both patterns match on one strobe, both flags are high in the same cycle.
- R4: A match needs at least 16 strobes accepted since hunting last began (reset, re-arm, manual start or reactivation). Bits from before that point never take part in a match.
- R5: `framing` goes high in the same cycle as a hit flag. From then on, each 8 accepted strobes form a byte, first bit in bit 7. `byte_valid` is a one-cycle pulse after the edge that samples the 8th bit, with `byte_data` holding the byte.
- R6: The checksum is a CRC-16 with polynomial x^16+x^12+x^5+1, fed MSB first, with the register set to zero whenever framing starts. When `byte_valid` pulses, `crc_ok` is 1 exactly when the register is zero after that byte, so appending the high and then the low byte of the CRC gives 1. `crc_ok` and `byte_data` hold until the next byte and are cleared when framing starts.
- R7: While framing, no pattern is matched. A `rearm` pulse returns the block to hunting with an empty history. A strobe in the same cycle as `rearm` is dropped.
- R8: A `manual_start` pulse while the receiver is active starts framing, or restarts it with a cleared CRC and bit count if framing was already on. A strobe in the same cycle is dropped.
- R9: The receiver is active only when `rx_enable` is 1 and `tx_enable` is 0. While it is inactive, strobes are ignored, framing is dropped and the history is emptied.
- R10: When `rearm` and `manual_start` arrive in the same cycle, `rearm` wins and the block hunts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_enable | input | 1 | Receiver enable |
| tx_enable | input | 1 | Transmitter enable; forces the receiver idle |
| std_sel | input | 1 | Selects which standard fixed pattern is used |
| user_word | input | 16 | User-programmed sync pattern |
| bit_valid | input | 1 | Strobe qualifying `bit_in` |
| bit_in | input | 1 | Sliced receive bit |
| manual_start | input | 1 | Pulse: start byte framing now |
| rearm | input | 1 | Pulse: leave framing and hunt again |
| fixed_hit | output | 1 | Fixed pattern found (one cycle) |
| user_hit | output | 1 | User pattern found (one cycle) |
| framing | output | 1 | Byte-framed mode active |
| byte_valid | output | 1 | Byte completed (one cycle) |
| byte_data | output | 8 | Last completed byte |
| crc_ok | output | 1 | CRC residue zero after last byte |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is the two matchers: the bench programs the user word equal to the selected fixed pattern, then expects both flags on the one cycle after the final bit. The second pair is a control pulse and a data strobe: the bench raises `rearm` or `manual_start` on the same edge as a strobe. It then shows that the bit was dropped, because a user word of all zeros fires only on the 16th following zero, and because the next byte holds exactly the eight bits sent after the start.

// File: rtl/sdet_pkg.sv
package sdet_pkg;

    localparam int SYNC_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int CRC_W     = 16;
    localparam int NUM_PAT   = 2;
    localparam int PAT_FIXED = 0;
    localparam int PAT_USER  = 1;

    localparam logic [CRC_W-1:0]  CRC_POLY  = 16'h1021;
    localparam logic [SYNC_W-1:0] STD0_WORD = 16'hC4D7;
    localparam logic [SYNC_W-1:0] STD1_WORD = 16'hB433;

    typedef enum logic {
        MODE_HUNT  = 1'b0,
        MODE_FRAME = 1'b1
    } rx_mode_e;

    typedef struct packed {
        logic              valid;
        logic              ok;
        logic [BYTE_W-1:0] data;
    } byte_rpt_t;

    function automatic logic [CRC_W-1:0] crc_shift(input logic [CRC_W-1:0] c,
                                                   input logic b);
        logic fb;
        fb = b ^ c[CRC_W-1];
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

    function automatic logic [SYNC_W-1:0] fixed_word(input logic sel);
        return sel ? STD1_WORD : STD0_WORD;
    endfunction

endpackage

// File: rtl/sdet_hunter.sv
module sdet_hunter
    import sdet_pkg::*;
#(
    parameter int W    = SYNC_W,
    parameter int NPAT = NUM_PAT
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clear,
    input  logic                     shift_en,
    input  logic                     bit_in,
    input  logic [NPAT-1:0][W-1:0]   patterns,
    output logic [NPAT-1:0]          hit
);
    localparam int FILL_W = $clog2(W + 1);

    logic [W-1:0]      sreg_q;
    logic [W-1:0]      sreg_next;
    logic [FILL_W-1:0] fill_q;
    logic              full_next;

    always_comb begin
        sreg_next = {sreg_q[W-2:0], bit_in};
        full_next = (fill_q >= FILL_W'(W - 1));
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sreg_q <= '0;
            fill_q <= '0;
        end else if (shift_en) begin
            sreg_q <= sreg_next;
            if (fill_q != FILL_W'(W))
                fill_q <= fill_q + 1'b1;
        end
    end

    for (genvar g = 0; g < NPAT; g++) begin : g_cmp
        assign hit[g] = shift_en && full_next && (sreg_next == patterns[g]);
    end

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
        fill_q <= FILL_W'(W)); // R4

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        $past(clear) |-> (fill_q == '0)); // R4

endmodule

// File: rtl/sdet_framer.sv
module sdet_framer
    import sdet_pkg::*;
#(
    parameter int BW = BYTE_W
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      restart,
    input  logic      shift_en,
    input  logic      bit_in,
    output byte_rpt_t rpt
);
    localparam int CNT_W = $clog2(BW);

    logic [BW-1:0]    acc_q;
    logic [BW-1:0]    acc_next;
    logic [CNT_W-1:0] cnt_q;
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_next;
    logic             last_bit;
    byte_rpt_t        rpt_q;

    always_comb begin
        acc_next = {acc_q[BW-2:0], bit_in};
        crc_next = crc_shift(crc_q, bit_in);
        last_bit = (cnt_q == CNT_W'(BW - 1));
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            acc_q <= '0;
            cnt_q <= '0;
            crc_q <= '0;
            rpt_q <= '0;
        end else begin
            rpt_q.valid <= 1'b0;
            if (shift_en) begin
                acc_q <= acc_next;
                crc_q <= crc_next;
                if (last_bit) begin
                    cnt_q      <= '0;
                    rpt_q.valid <= 1'b1;
                    rpt_q.ok   <= (crc_next == '0);
                    rpt_q.data <= acc_next;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign rpt = rpt_q;

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rpt_q.valid |=> !rpt_q.valid); // R5

    AST_OK_MOVES_ON_BYTE: assert property (@(posedge clk) disable iff (rst)
        !$stable(rpt_q.ok) |-> (rpt_q.valid || $past(restart))); // R6

endmodule

// File: rtl/sync_word_detector.sv
module sync_word_detector
    import sdet_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_enable,
    input  logic        tx_enable,
    input  logic        std_sel,
    input  logic [15:0] user_word,
    input  logic        bit_valid,
    input  logic        bit_in,
    input  logic        manual_start,
    input  logic        rearm,
    output logic        fixed_hit,
    output logic        user_hit,
    output logic        framing,
    output logic        byte_valid,
    output logic [7:0]  byte_data,
    output logic        crc_ok
);
    rx_mode_e                       mode_q;
    logic                           active;
    logic                           hunt_shift;
    logic                           frame_shift;
    logic                           hunt_clear;
    logic                           go_frame;
    logic                           frame_restart;
    logic [NUM_PAT-1:0][SYNC_W-1:0] pats;
    logic [NUM_PAT-1:0]             hit;
    logic [NUM_PAT-1:0]             hit_q;
    byte_rpt_t                      rpt;

    always_comb begin
        active        = rx_enable && !tx_enable;
        hunt_shift    = active && (mode_q == MODE_HUNT) && bit_valid && !rearm && !manual_start;
        frame_shift   = active && (mode_q == MODE_FRAME) && bit_valid && !rearm && !manual_start;
        hunt_clear    = !active || rearm || manual_start || (mode_q == MODE_FRAME);
        pats[PAT_FIXED] = fixed_word(std_sel);
        pats[PAT_USER]  = user_word;
        go_frame      = (active && !rearm && manual_start) || (|hit);
        frame_restart = !active || rearm || go_frame;
    end

    sdet_hunter #(.W(SYNC_W), .NPAT(NUM_PAT)) u_hunter (
        .clk      (clk),
        .rst      (rst),
        .clear    (hunt_clear),
        .shift_en (hunt_shift),
        .bit_in   (bit_in),
        .patterns (pats),
        .hit      (hit)
    );

    sdet_framer #(.BW(BYTE_W)) u_framer (
        .clk      (clk),
        .rst      (rst),
        .restart  (frame_restart),
        .shift_en (frame_shift),
        .bit_in   (bit_in),
        .rpt      (rpt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_HUNT;
            hit_q  <= '0;
        end else begin
            hit_q <= hit;
            if (!active || rearm)
                mode_q <= MODE_HUNT;
            else if (go_frame)
                mode_q <= MODE_FRAME;
        end
    end

    assign fixed_hit  = hit_q[PAT_FIXED];
    assign user_hit   = hit_q[PAT_USER];
    assign framing    = (mode_q == MODE_FRAME);
    assign byte_valid = rpt.valid;
    assign byte_data  = rpt.data;
    assign crc_ok     = rpt.ok;

    AST_HIT_ENTERS_FRAME: assert property (@(posedge clk) disable iff (rst)
        (fixed_hit || user_hit) |-> framing); // R5

    AST_NO_MATCH_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        $past(framing) |-> !(fixed_hit || user_hit)); // R7

    AST_IDLE_WHEN_INACTIVE: assert property (@(posedge clk) disable iff (rst)
        !$past(rx_enable && !tx_enable) |-> (!framing && !fixed_hit && !user_hit)); // R9

    AST_REARM_WINS: assert property (@(posedge clk) disable iff (rst)
        $past(rearm) |-> !framing); // R10

    AST_MANUAL_FRAMES: assert property (@(posedge clk) disable iff (rst)
        $past(manual_start && rx_enable && !tx_enable && !rearm) |-> (framing && !byte_valid && !crc_ok)); // R8

endmodule

// File: tb/sync_word_detector_tb.sv
`timescale 1ns/1ps
module sync_word_detector_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_enable = 1'b1;
    logic        tx_enable = 1'b0;
    logic        std_sel = 1'b0;
    logic [15:0] user_word = 16'h5A0F;
    logic        bit_valid = 1'b0;
    logic        bit_in = 1'b0;
    logic        manual_start = 1'b0;
    logic        rearm = 1'b0;
    logic        fixed_hit, user_hit, framing, byte_valid, crc_ok;
    logic [7:0]  byte_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] cap_data [0:15];
    logic       cap_ok   [0:15];
    int         ncap = 0;

    always #4 clk = ~clk;

    sync_word_detector u_dut (
        .clk(clk), .rst(rst), .rx_enable(rx_enable), .tx_enable(tx_enable),
        .std_sel(std_sel), .user_word(user_word), .bit_valid(bit_valid),
        .bit_in(bit_in), .manual_start(manual_start), .rearm(rearm),
        .fixed_hit(fixed_hit), .user_hit(user_hit), .framing(framing),
        .byte_valid(byte_valid), .byte_data(byte_data), .crc_ok(crc_ok)
    );

    always @(negedge clk) begin
        if (byte_valid && ncap < 16) begin
            cap_data[ncap] = byte_data;
            cap_ok[ncap]   = crc_ok;
            ncap++;
        end
    end

    task automatic chk(input bit cond, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c ^ {b, 8'h00};
        for (int k = 0; k < 8; k++)
            r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        return r;
    endfunction

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_valid = 1'b1;
        bit_in    = b;
        @(posedge clk);
        #1;
        bit_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_rearm();
        @(negedge clk);
        rearm = 1'b1;
        @(posedge clk);
        #1;
        rearm = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        idle(3);
        @(negedge clk);
        rst = 1'b0;
        idle(1);
        chk(!framing && !fixed_hit && !user_hit, "R1", "hunt flags after reset",
            {framing, fixed_hit, user_hit}, 0);
        chk(!byte_valid && byte_data == 8'h00 && !crc_ok, "R1", "byte outputs after reset",
            {byte_valid, byte_data, crc_ok}, 0);
    endtask

    task automatic t_fixed_std0();
        logic [15:0] p = 16'hC4D7;
        std_sel = 1'b0;
        user_word = 16'h5A0F;
        send_byte(8'hA5);
        for (int i = 15; i >= 1; i--) send_bit(p[i]);
        chk(!fixed_hit && !framing, "R2", "no hit before final bit", {fixed_hit, framing}, 0);
        send_bit(p[0]);
        chk(fixed_hit && !user_hit, "R2", "std0 fixed hit", {fixed_hit, user_hit}, 2'b10);
        chk(framing, "R5", "framing with hit", framing, 1);
        idle(1);
        chk(!fixed_hit && framing, "R2", "hit is one cycle", {fixed_hit, framing}, 2'b01);
    endtask

    task automatic t_crc_bytes();
        logic [7:0]  msg [0:3];
        logic [15:0] c = 16'h0000;
        logic [15:0] fin;
        msg[0] = 8'h12;
        msg[1] = 8'h34;
        fin = crc_byte(crc_byte(16'h0000, 8'h12), 8'h34);
        msg[2] = fin[15:8];
        msg[3] = fin[7:0];
        ncap = 0;
        for (int i = 0; i < 4; i++) send_byte(msg[i]);
        idle(2);
        chk(ncap == 4, "R5", "byte count", ncap, 4);
        for (int i = 0; i < 4; i++) begin
            c = crc_byte(c, msg[i]);
            chk(cap_data[i] == msg[i], "R5", "byte value", cap_data[i], msg[i]);
            chk(cap_ok[i] == (c == 16'h0000), "R6", "crc flag per byte", cap_ok[i], (c == 16'h0000));
        end
        chk(crc_ok && byte_data == msg[3], "R6", "flag and byte held", {crc_ok, byte_data}, {1'b1, msg[3]});
    endtask

    task automatic t_fixed_std1();
        pulse_rearm();
        chk(!framing, "R7", "rearm leaves framing", framing, 0);
        std_sel = 1'b1;
        send_word(16'hC4D7);
        chk(!fixed_hit && !framing, "R2", "std0 word ignored with sel=1", {fixed_hit, framing}, 0);
        send_word(16'hB433);
        chk(fixed_hit && !user_hit && framing, "R2", "std1 fixed hit",
            {fixed_hit, user_hit, framing}, 3'b101);
    endtask

    task automatic t_user();
        pulse_rearm();
        std_sel = 1'b0;
        user_word = 16'h5A0F;
        send_word(16'h5A0F);
        chk(user_hit && !fixed_hit && framing, "R3", "user hit alone",
            {user_hit, fixed_hit, framing}, 3'b101);
    endtask

    task automatic t_both();
        pulse_rearm();
        std_sel = 1'b0;
        user_word = 16'hC4D7;
        send_word(16'hC4D7);
        chk(user_hit && fixed_hit, "R3", "both hits same cycle", {user_hit, fixed_hit}, 2'b11);
    endtask

    task automatic t_suspend();
        logic seen = 1'b0;
        ncap = 0;
        for (int i = 15; i >= 0; i--) begin
            send_bit(16'hC4D7 >> i);
            if (fixed_hit || user_hit) seen = 1'b1;
        end
        chk(!seen && framing, "R7", "no match while framing", {seen, framing}, 2'b01);
        idle(1);
        chk(ncap == 2 && cap_data[0] == 8'hC4 && cap_data[1] == 8'hD7, "R5", "pattern framed as data",
            {cap_data[0], cap_data[1]}, 16'hC4D7);
        pulse_rearm();
        send_word(16'hC4D7);
        chk(fixed_hit, "R7", "match after rearm", fixed_hit, 1);
    endtask

    task automatic t_rearm_collide();
        user_word = 16'h0000;
        @(negedge clk);
        rearm = 1'b1; bit_valid = 1'b1; bit_in = 1'b0;
        @(posedge clk);
        #1;
        rearm = 1'b0; bit_valid = 1'b0;
        chk(!framing, "R7", "framing dropped by rearm", framing, 0);
        for (int i = 0; i < 15; i++) send_bit(1'b0);
        chk(!user_hit, "R4", "15 zeros after rearm do not match", user_hit, 0);
        send_bit(1'b0);
        chk(user_hit, "R4", "16th zero matches", user_hit, 1);
        @(negedge clk);
        rearm = 1'b1; manual_start = 1'b1;
        @(posedge clk);
        #1;
        rearm = 1'b0; manual_start = 1'b0;
        chk(!framing, "R10", "rearm beats manual start", framing, 0);
    endtask

    task automatic t_manual();
        user_word = 16'h5A0F;
        @(negedge clk);
        manual_start = 1'b1; bit_valid = 1'b1; bit_in = 1'b1;
        @(posedge clk);
        #1;
        manual_start = 1'b0; bit_valid = 1'b0;
        chk(framing && !crc_ok && byte_data == 8'h00, "R8", "manual start frames",
            {framing, crc_ok, byte_data}, 10'h200);
        ncap = 0;
        send_byte(8'h5C);
        idle(1);
        chk(ncap == 1 && cap_data[0] == 8'h5C, "R8", "collided bit dropped", cap_data[0], 8'h5C);
        chk(cap_ok[0] == (crc_byte(16'h0, 8'h5C) == 16'h0), "R6", "single byte flag", cap_ok[0], 0);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        @(negedge clk);
        manual_start = 1'b1;
        @(posedge clk);
        #1;
        manual_start = 1'b0;
        ncap = 0;
        send_byte(8'h3A);
        idle(1);
        chk(ncap == 1 && cap_data[0] == 8'h3A, "R8", "restart realigns byte", cap_data[0], 8'h3A);
        chk(cap_ok[0] == (crc_byte(16'h0, 8'h3A) == 16'h0), "R8", "restart clears crc", cap_ok[0], 0);
    endtask

    task automatic t_half_duplex();
        logic seen = 1'b0;
        @(negedge clk);
        tx_enable = 1'b1;
        idle(1);
        chk(!framing, "R9", "tx enable drops framing", framing, 0);
        for (int i = 15; i >= 0; i--) begin
            send_bit(16'hC4D7 >> i);
            if (fixed_hit || framing) seen = 1'b1;
        end
        chk(!seen, "R9", "ignored while tx enabled", seen, 0);
        tx_enable = 1'b0;
        rx_enable = 1'b0;
        send_word(16'hC4D7);
        chk(!fixed_hit && !framing, "R9", "ignored while rx disabled", {fixed_hit, framing}, 0);
        rx_enable = 1'b1;
        send_word(16'hC4D7);
        chk(fixed_hit && framing, "R9", "match after reactivation", {fixed_hit, framing}, 2'b11);
    endtask

    initial begin
        t_reset();
        t_fixed_std0();
        t_crc_bytes();
        t_fixed_std1();
        t_user();
        t_both();
        t_suspend();
        t_rearm_collide();
        t_manual();
        t_half_duplex();
        idle(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule